// File: doc/BRIEF.md
# Banked Register-File Read Crossbar

This block is the combinational steering stage between a set of register-file read requesters and a set of banks. Each bank offers a fixed number of read ports. Every requester presents a valid bit and an address. The high part of the address names the bank, and the low part names the register inside that bank. Each bank read port signals through its ready input that it can serve a read this cycle. The block gives each ready port at most one requester. It forwards that requester's address on the port and raises the port's valid. The same cycle, it returns the port's data and an ack to the requester.

Grants are made in one fixed priority walk. Bank 0 is visited first, and inside a bank the lowest port number is visited first. Each port scans its candidate requesters from the lowest candidate index upward. A requester that one port takes is busy for every port visited after it, so no requester is served twice. A parameter selects which requesters are candidates for a port:
- In full mode, every requester is a candidate for every port.
- In strided mode, port j of each bank sees only the requesters j, j+P, j+2P and so on, where P is the number of ports per bank.

Top module: `rf_bank_read_xbar`

## Requirements
- R1: A requester's target bank is the unsigned value of address bits [ADDR_W-1:SHIFT_ADDRESS]. A port of bank b only grants requesters whose bank field equals b, so a bank field of NUM_BANK or more is never granted.
- R2: A requester whose valid is low is treated as busy from the start and never receives an ack.
- R3: A bank port whose ready is low grants nothing. Its valid is 0, its forwarded address is 0, and all of its candidate-free flags are 0.
- R4: In full mode (FULL_XBAR=1), candidate k of every port is requester k, for all NUM_REQ requesters.
- R5: In strided mode (FULL_XBAR=0), candidate k of port j in any bank is requester k*PORTS_PER_BANK+j. A requester outside that set is never granted by that port, and its free flag on that port stays 0.
- R6: Within one port, candidates are scanned in increasing k. The first candidate that is not busy and targets the port's bank is granted, and the scan then stops.
- R7: Ports are visited in ascending order of bank and then of port within the bank (flat index g = bank*PORTS_PER_BANK + port). A granted requester becomes busy for all later ports, so each requester is acked at most once. The number of acked requesters therefore equals the number of valid ports.
- R8: For a grant, the requester's ack is 1 and its data equals the granting port's data. On the port side, valid is 1 and the forwarded address is the requester's full address.
- R9: The free flag of candidate r on port g (bit g*NUM_REQ+r) equals the port's ready ANDed with requester r not being busy when port g is evaluated.
- R10: A requester with no grant drives ack 0 and data 0. With all inputs at zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | NUM_REQ | Read request valid per requester |
| req_addr | input | NUM_REQ*ADDR_W | Request addresses, requester r at bits [r*ADDR_W +: ADDR_W] |
| req_ack | output | NUM_REQ | Request granted this cycle |
| req_data | output | NUM_REQ*DATA_W | Returned data, requester r at [r*DATA_W +: DATA_W] |
| port_valid | output | NUM_BANK*PORTS_PER_BANK | Bank port carries a granted read |
| port_addr | output | NUM_BANK*PORTS_PER_BANK*ADDR_W | Address forwarded to bank port g |
| port_ready | input | NUM_BANK*PORTS_PER_BANK | Bank port can accept a read |
| port_data | input | NUM_BANK*PORTS_PER_BANK*DATA_W | Data presented by bank port g |
| port_cand_free | output | NUM_BANK*PORTS_PER_BANK*NUM_REQ | Per port, per requester: ready and not yet busy |

## Verification
The block holds no state, so every output is due in the same cycle as the inputs that cause it. No register stands between any input and any output. The bench changes inputs just after a falling clock edge and samples all outputs a quarter period later, once the combinational paths have settled and well away from either edge. Two instances receive identical stimulus, one in full mode and one in strided mode. Each is compared against a bench model that repeats the priority walk.

// File: rtl/rbx_pkg.sv
package rbx_pkg;

    // Requester index seen as candidate k of port j.
    function automatic int cand_req(input bit full, input int k, input int j, input int ppb);
        return full ? k : (k * ppb + j);
    endfunction

    // Number of candidates port j scans.
    function automatic int cand_count(input bit full, input int nreq, input int j, input int ppb);
        if (full)
            return nreq;
        if (j >= nreq)
            return 0;
        return (nreq - j + ppb - 1) / ppb;
    endfunction

endpackage

// File: rtl/rbx_bank_decode.sv
module rbx_bank_decode #(
    parameter int NUM_REQ       = 6,
    parameter int NUM_BANK      = 2,
    parameter int ADDR_W        = 6,
    parameter int SHIFT_ADDRESS = 4
) (
    input  logic [NUM_REQ*ADDR_W-1:0]   req_addr,
    output logic [NUM_BANK*NUM_REQ-1:0] bank_hit
);
    localparam int BANK_W = ADDR_W - SHIFT_ADDRESS;

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        logic [BANK_W-1:0] bank_field;
        assign bank_field = req_addr[r*ADDR_W+SHIFT_ADDRESS +: BANK_W];
        for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
            assign bank_hit[b*NUM_REQ+r] = (32'(bank_field) == 32'(b));
        end
    end
endmodule

// File: rtl/rbx_port_arbiter.sv
module rbx_port_arbiter #(
    parameter int NUM_REQ        = 6,
    parameter int PORTS_PER_BANK = 2,
    parameter int PORT_IDX       = 0,
    parameter bit FULL_XBAR      = 1'b1
) (
    input  logic               ready,
    input  logic [NUM_REQ-1:0] busy_in,
    input  logic [NUM_REQ-1:0] bank_hit,
    output logic [NUM_REQ-1:0] grant,
    output logic [NUM_REQ-1:0] cand_free
);
    localparam int NCAND = rbx_pkg::cand_count(FULL_XBAR, NUM_REQ, PORT_IDX, PORTS_PER_BANK);

    typedef struct packed {
        logic               found;
        logic [NUM_REQ-1:0] busy;
        logic [NUM_REQ-1:0] grant;
        logic [NUM_REQ-1:0] free;
    } arb_t;

    arb_t arb_d;

    always_comb begin
        arb_d       = '0;
        arb_d.busy  = busy_in;
        for (int k = 0; k < NCAND; k++) begin
            int r;
            r = rbx_pkg::cand_req(FULL_XBAR, k, PORT_IDX, PORTS_PER_BANK);
            arb_d.free[r] = ready & ~arb_d.busy[r];
            if (ready && !arb_d.found && !arb_d.busy[r] && bank_hit[r]) begin
                arb_d.grant[r] = 1'b1;
                arb_d.busy[r]  = 1'b1;
                arb_d.found    = 1'b1;
            end
        end
    end

    assign grant     = arb_d.grant;
    assign cand_free = arb_d.free;
endmodule

// File: rtl/rbx_return_mux.sv
module rbx_return_mux #(
    parameter int NUM_REQ   = 6,
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8
) (
    input  logic [NUM_PORTS*NUM_REQ-1:0] grant,
    input  logic [NUM_REQ*ADDR_W-1:0]    req_addr,
    input  logic [NUM_PORTS*DATA_W-1:0]  port_data,
    output logic [NUM_REQ-1:0]           req_ack,
    output logic [NUM_REQ*DATA_W-1:0]    req_data,
    output logic [NUM_PORTS-1:0]         port_valid,
    output logic [NUM_PORTS*ADDR_W-1:0]  port_addr
);
    typedef struct packed {
        logic [NUM_REQ-1:0]          ack;
        logic [NUM_REQ*DATA_W-1:0]   data;
        logic [NUM_PORTS-1:0]        pvalid;
        logic [NUM_PORTS*ADDR_W-1:0] paddr;
    } ret_t;

    ret_t ret_d;

    always_comb begin
        ret_d = '0;
        for (int g = 0; g < NUM_PORTS; g++) begin
            for (int r = 0; r < NUM_REQ; r++) begin
                if (grant[g*NUM_REQ+r]) begin
                    ret_d.ack[r]                     = 1'b1;
                    ret_d.data[r*DATA_W +: DATA_W]  |= port_data[g*DATA_W +: DATA_W];
                    ret_d.pvalid[g]                  = 1'b1;
                    ret_d.paddr[g*ADDR_W +: ADDR_W] |= req_addr[r*ADDR_W +: ADDR_W];
                end
            end
        end
    end

    assign req_ack    = ret_d.ack;
    assign req_data   = ret_d.data;
    assign port_valid = ret_d.pvalid;
    assign port_addr  = ret_d.paddr;
endmodule

// File: rtl/rf_bank_read_xbar.sv
module rf_bank_read_xbar #(
    parameter int NUM_REQ        = 6,
    parameter int NUM_BANK       = 2,
    parameter int PORTS_PER_BANK = 2,
    parameter int ADDR_W         = 6,
    parameter int DATA_W         = 8,
    parameter int SHIFT_ADDRESS  = 4,
    parameter bit FULL_XBAR      = 1'b1
) (
    input  logic [NUM_REQ-1:0]                          req_valid,
    input  logic [NUM_REQ*ADDR_W-1:0]                   req_addr,
    output logic [NUM_REQ-1:0]                          req_ack,
    output logic [NUM_REQ*DATA_W-1:0]                   req_data,
    output logic [NUM_BANK*PORTS_PER_BANK-1:0]          port_valid,
    output logic [NUM_BANK*PORTS_PER_BANK*ADDR_W-1:0]   port_addr,
    input  logic [NUM_BANK*PORTS_PER_BANK-1:0]          port_ready,
    input  logic [NUM_BANK*PORTS_PER_BANK*DATA_W-1:0]   port_data,
    output logic [NUM_BANK*PORTS_PER_BANK*NUM_REQ-1:0]  port_cand_free
);
    localparam int NUM_PORTS = NUM_BANK * PORTS_PER_BANK;

    logic [NUM_BANK*NUM_REQ-1:0]  bank_hit;
    logic [NUM_PORTS*NUM_REQ-1:0] grant_all;
    logic [NUM_PORTS-1:0][NUM_REQ-1:0] busy_chain;

    rbx_bank_decode #(
        .NUM_REQ(NUM_REQ), .NUM_BANK(NUM_BANK),
        .ADDR_W(ADDR_W), .SHIFT_ADDRESS(SHIFT_ADDRESS)
    ) u_decode (
        .req_addr(req_addr),
        .bank_hit(bank_hit)
    );

    assign busy_chain[0] = ~req_valid;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        localparam int BANK = g / PORTS_PER_BANK;
        localparam int PIDX = g % PORTS_PER_BANK;

        rbx_port_arbiter #(
            .NUM_REQ(NUM_REQ), .PORTS_PER_BANK(PORTS_PER_BANK),
            .PORT_IDX(PIDX), .FULL_XBAR(FULL_XBAR)
        ) u_arb (
            .ready    (port_ready[g]),
            .busy_in  (busy_chain[g]),
            .bank_hit (bank_hit[BANK*NUM_REQ +: NUM_REQ]),
            .grant    (grant_all[g*NUM_REQ +: NUM_REQ]),
            .cand_free(port_cand_free[g*NUM_REQ +: NUM_REQ])
        );

        if (g < NUM_PORTS - 1) begin : g_chain
            assign busy_chain[g+1] = busy_chain[g] | grant_all[g*NUM_REQ +: NUM_REQ];
        end
    end

    rbx_return_mux #(
        .NUM_REQ(NUM_REQ), .NUM_PORTS(NUM_PORTS),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_ret (
        .grant     (grant_all),
        .req_addr  (req_addr),
        .port_data (port_data),
        .req_ack   (req_ack),
        .req_data  (req_data),
        .port_valid(port_valid),
        .port_addr (port_addr)
    );
endmodule

// File: rtl/rbx_checker.sv
module rbx_checker #(
    parameter int NUM_REQ        = 6,
    parameter int NUM_BANK       = 2,
    parameter int PORTS_PER_BANK = 2,
    parameter int ADDR_W         = 6,
    parameter int DATA_W         = 8,
    parameter int SHIFT_ADDRESS  = 4,
    parameter bit FULL_XBAR      = 1'b1
) (
    input logic [NUM_REQ-1:0]                          req_valid,
    input logic [NUM_REQ-1:0]                          req_ack,
    input logic [NUM_BANK*PORTS_PER_BANK-1:0]          port_valid,
    input logic [NUM_BANK*PORTS_PER_BANK*ADDR_W-1:0]   port_addr,
    input logic [NUM_BANK*PORTS_PER_BANK-1:0]          port_ready,
    input logic [NUM_BANK*PORTS_PER_BANK*NUM_REQ-1:0]  port_cand_free
);
    localparam int NUM_PORTS = NUM_BANK * PORTS_PER_BANK;
    localparam int BANK_W    = ADDR_W - SHIFT_ADDRESS;

    always_comb begin
        // R2: an invalid requester never sees an ack
        p_invalid_no_ack_r2: assert ((req_ack & ~req_valid) == '0)
            else $error("invalid requester acked");

        // R7: one ack per valid port, so no requester is claimed twice
        p_one_claim_r7: assert ($countones(req_ack) == $countones(port_valid))
            else $error("ack count differs from port valid count");

        for (int g = 0; g < NUM_PORTS; g++) begin
            // R3: an unready port is fully idle
            p_idle_port_r3: assert (port_ready[g] ||
                (!port_valid[g] && port_addr[g*ADDR_W +: ADDR_W] == '0 &&
                 port_cand_free[g*NUM_REQ +: NUM_REQ] == '0))
                else $error("unready port %0d not idle", g);

            // R1: forwarded address targets the port's own bank
            p_bank_match_r1: assert (!port_valid[g] ||
                32'(port_addr[g*ADDR_W+SHIFT_ADDRESS +: BANK_W]) == 32'(g / PORTS_PER_BANK))
                else $error("port %0d forwarded a foreign bank", g);

            // R5: in strided mode, off-stride requesters are never free on this port
            for (int r = 0; r < NUM_REQ; r++) begin
                p_stride_r5: assert (FULL_XBAR || (r % PORTS_PER_BANK) == (g % PORTS_PER_BANK) ||
                    !port_cand_free[g*NUM_REQ+r])
                    else $error("port %0d flags off-stride requester %0d", g, r);
            end
        end
    end
endmodule

bind rf_bank_read_xbar rbx_checker #(
    .NUM_REQ(NUM_REQ), .NUM_BANK(NUM_BANK), .PORTS_PER_BANK(PORTS_PER_BANK),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHIFT_ADDRESS(SHIFT_ADDRESS), .FULL_XBAR(FULL_XBAR)
) u_rbx_chk (
    .req_valid(req_valid), .req_ack(req_ack), .port_valid(port_valid),
    .port_addr(port_addr), .port_ready(port_ready), .port_cand_free(port_cand_free)
);

// File: tb/rf_bank_read_xbar_tb.sv
module rf_bank_read_xbar_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 6;
    localparam int B  = 2;
    localparam int P  = 2;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int SH = 4;
    localparam int NP = B * P;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [N-1:0]     rv;
    logic [N*AW-1:0]  ra;
    logic [NP-1:0]    prdy;
    logic [NP*DW-1:0] pd;

    logic [N-1:0]     f_ack,  s_ack;
    logic [N*DW-1:0]  f_data, s_data;
    logic [NP-1:0]    f_pv,   s_pv;
    logic [NP*AW-1:0] f_pa,   s_pa;
    logic [NP*N-1:0]  f_free, s_free;

    rf_bank_read_xbar #(.NUM_REQ(N), .NUM_BANK(B), .PORTS_PER_BANK(P), .ADDR_W(AW),
        .DATA_W(DW), .SHIFT_ADDRESS(SH), .FULL_XBAR(1'b1)) dut_i (
        .req_valid(rv), .req_addr(ra), .req_ack(f_ack), .req_data(f_data),
        .port_valid(f_pv), .port_addr(f_pa), .port_ready(prdy), .port_data(pd),
        .port_cand_free(f_free));

    rf_bank_read_xbar #(.NUM_REQ(N), .NUM_BANK(B), .PORTS_PER_BANK(P), .ADDR_W(AW),
        .DATA_W(DW), .SHIFT_ADDRESS(SH), .FULL_XBAR(1'b0)) dut_part_i (
        .req_valid(rv), .req_addr(ra), .req_ack(s_ack), .req_data(s_data),
        .port_valid(s_pv), .port_addr(s_pa), .port_ready(prdy), .port_data(pd),
        .port_cand_free(s_free));

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Bench model of the priority walk
    task automatic model(input bit full, output logic [63:0] e_ack, output logic [63:0] e_data,
                         output logic [63:0] e_pv, output logic [63:0] e_pa,
                         output logic [63:0] e_free);
        logic [N-1:0] busy;
        e_ack = '0; e_data = '0; e_pv = '0; e_pa = '0; e_free = '0;
        busy = ~rv;
        for (int b = 0; b < B; b++) begin
            for (int j = 0; j < P; j++) begin
                int g;
                int nc;
                bit found;
                g = b * P + j;
                nc = full ? N : (N - j + P - 1) / P;
                found = 1'b0;
                for (int k = 0; k < nc; k++) begin
                    int r;
                    r = full ? k : k * P + j;
                    e_free[g*N+r] = prdy[g] & ~busy[r];
                    if (prdy[g] && !found && !busy[r] && int'(ra[r*AW+SH +: AW-SH]) == b) begin
                        found = 1'b1;
                        busy[r] = 1'b1;
                        e_ack[r] = 1'b1;
                        e_data[r*DW +: DW] = pd[g*DW +: DW];
                        e_pv[g] = 1'b1;
                        e_pa[g*AW +: AW] = ra[r*AW +: AW];
                    end
                end
            end
        end
    endtask

    task automatic compare_all(input string tag);
        logic [63:0] ea, ed, ev, ep, ef;
        model(1'b1, ea, ed, ev, ep, ef);
        chk({tag, " R2 R7 full"}, "req_ack",  64'(f_ack),  ea);
        chk({tag, " R8 R10 full"}, "req_data", 64'(f_data), ed);
        chk({tag, " R3 R8 full"}, "port_valid", 64'(f_pv), ev);
        chk({tag, " R1 R8 full"}, "port_addr", 64'(f_pa), ep);
        chk({tag, " R4 R9 full"}, "cand_free", 64'(f_free), ef);
        model(1'b0, ea, ed, ev, ep, ef);
        chk({tag, " R5 R7 strided"}, "req_ack",  64'(s_ack),  ea);
        chk({tag, " R8 R10 strided"}, "req_data", 64'(s_data), ed);
        chk({tag, " R3 R8 strided"}, "port_valid", 64'(s_pv), ev);
        chk({tag, " R1 R8 strided"}, "port_addr", 64'(s_pa), ep);
        chk({tag, " R5 R9 strided"}, "cand_free", 64'(s_free), ef);
    endtask

    task automatic set_req(input int r, input bit v, input int bank, input int idx);
        rv[r] = v;
        ra[r*AW +: AW] = AW'((bank << SH) | (idx & ((1 << SH) - 1)));
    endtask

    task automatic settle();
        #(CLK_PERIOD/4);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        rv = '0; ra = '0; prdy = '0; pd = '0;
        for (int g = 0; g < NP; g++) pd[g*DW +: DW] = DW'(8'hA0 + g);

        // Idle: all zero requests and ports
        @(negedge clk); rv = '0; ra = '0; prdy = '0; pd = '0; settle();
        chk("R10 idle", "req_ack", 64'(f_ack), 64'd0);
        chk("R10 idle", "port_addr", 64'(f_pa), 64'd0);
        compare_all("idle");
        for (int g = 0; g < NP; g++) pd[g*DW +: DW] = DW'(8'hA0 + g);

        // All valid, all bank 0, all ports ready: lowest candidates win
        @(negedge clk);
        for (int r = 0; r < N; r++) set_req(r, 1'b1, 0, r);
        prdy = '1; settle();
        chk("R6 lowest-first full", "req_ack", 64'(f_ack), 64'b000011);
        chk("R6 lowest-first strided", "req_ack", 64'(s_ack), 64'b000011);
        chk("R8 data full", "req_data", 64'(f_data[2*DW-1:0]), 64'hA1A0);
        compare_all("all_bank0");

        // Requester 0 invalid: skipped
        @(negedge clk); set_req(0, 1'b0, 0, 0); settle();
        chk("R2 skip invalid full", "req_ack", 64'(f_ack), 64'b000110);
        chk("R2 skip invalid strided", "req_ack", 64'(s_ack), 64'b000110);
        compare_all("r0_invalid");

        // Bank 0 port 0 not ready
        @(negedge clk); prdy = 4'b1110; settle();
        chk("R3 unready port", "port_valid", 64'(f_pv), 64'b0010);
        compare_all("p0_unready");

        // Only requester 1 valid, port 1 of bank 0 not ready: stride blocks it
        @(negedge clk);
        for (int r = 0; r < N; r++) set_req(r, 1'b0, 0, r);
        set_req(1, 1'b1, 0, 1); prdy = 4'b1101; settle();
        chk("R5 stride blocks", "req_ack", 64'(s_ack), 64'b000000);
        chk("R4 full reaches", "req_ack", 64'(f_ack), 64'b000010);
        compare_all("stride");

        // Out of range bank field is never granted
        @(negedge clk);
        for (int r = 0; r < N; r++) set_req(r, 1'b1, 2 + (r % 2), r);
        prdy = '1; settle();
        chk("R1 foreign bank", "req_ack", 64'(f_ack | s_ack), 64'd0);
        compare_all("oob_bank");

        // Contention for bank 1: requests split over both banks
        @(negedge clk);
        for (int r = 0; r < N; r++) set_req(r, 1'b1, (r < 4) ? 1 : 0, r);
        settle();
        chk("R7 bank1 pair full", "req_ack", 64'(f_ack), 64'b110011);
        compare_all("split");

        // Random mix
        for (int it = 0; it < 300; it++) begin
            @(negedge clk);
            for (int r = 0; r < N; r++) begin
                int bk;
                bk = ($urandom % 8 == 0) ? 2 + int'($urandom % 2) : int'($urandom % 2);
                set_req(r, 1'($urandom % 4 != 0), bk, int'($urandom));
            end
            prdy = NP'($urandom);
            pd   = (NP*DW)'({$urandom, $urandom});
            settle();
            compare_all("random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule